// File: doc/BRIEF.md
# EPROM Programming Bus Interface

This block sits on a synchronous memory bus and serves an 8 KiB address window, split into eight 1 KiB EPROM sockets. The window's position in the 64 KiB space is set by a 3-bit base selector (a value of 7 places it at E000h). A read that lands in the window is an ordinary ROM read: the addressed socket is selected and its data is returned in the same cycle, with no wait state. The block has no I/O-space decode.

A write that lands in the window starts a programming cycle. The bus master gives a one-cycle write strobe and then waits for the ready output. Ready drops in the same cycle as the strobe. The block captures the socket, the offset, the data and the level of the programming switch. It then runs three counted phases: select setup, program pulse and hold.

When the switch was on at capture time, the high-voltage chip-select enable is raised for all three phases, and the program pulse is raised only during the middle phase. When the switch was off, the cycle has the same length and the same select activity, but neither high-voltage output moves. Writes that arrive while a cycle is running are ignored. The analog supplies that act on these enables lie outside the block.

Top module: `eprog_bus_if`

## Requirements
- R1: The window is hit when `bus_addr[15:13]` equals `base_sel`. The socket is `bus_addr[12:10]` and the offset is `bus_addr[9:0]`. On an idle read or write hit, `sock_sel` has only bit `bus_addr[12:10]` set and `eprom_addr` equals the offset. With no hit, `sock_sel` is zero.
- R2: In idle, a read hit returns `eprom_rdata` on `bus_rdata` in the same cycle, with `bus_ready` high. Without a read hit, `bus_rdata` is zero.
- R3: A write hit in idle pulls `bus_ready` low in the same cycle. Ready stays low for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles after the capturing edge and is high in the following cycle.
- R4: With the switch on at capture, `hv_sel_en` is high in every busy cycle after the capturing edge and low once ready returns.
- R5: With the switch on at capture, `prog_pulse` is high for exactly PULSE_CYC cycles. It starts SETUP_CYC cycles after `hv_sel_en` rises and is never high without `hv_sel_en`.
- R6: With the switch off at capture, a write hit runs a cycle of the same length with `sock_sel` held, while `hv_sel_en` and `prog_pulse` stay low. The switch is sampled only at capture, so changes to it during a cycle have no effect.
- R7: A write outside the window leaves `bus_ready` high and `sock_sel` zero, and starts no cycle.
- R8: A write during a busy cycle is ignored. `sock_sel`, `eprom_addr` and `eprom_wdata` keep the captured values, the cycle ends at its original time, and no new cycle follows.
- R9: During and after reset, the block is idle: `bus_ready` is high, and `hv_sel_en`, `prog_pulse` and `sock_sel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 3 | Window base (upper address bits) |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Memory read strobe |
| bus_wr | input | 1 | Memory write strobe (one cycle) |
| prog_sw | input | 1 | Programming-enable switch level |
| eprom_rdata | input | 8 | Data from the selected socket |
| bus_rdata | output | 8 | Read data to the bus |
| bus_ready | output | 1 | High when the bus may proceed |
| sock_sel | output | 8 | One-hot socket select |
| eprom_addr | output | 10 | Offset within the socket |
| eprom_wdata | output | 8 | Captured programming data |
| hv_sel_en | output | 1 | High-voltage chip-select enable |
| prog_pulse | output | 1 | Programming pulse enable |

## Verification
Read data, idle socket decode and the drop of ready all settle combinationally in the cycle of the strobe. The bench drives inputs on the falling edge and checks one nanosecond later in that same cycle. For a programming write, the bench counts k from the first cycle after the capturing edge. It expects the pulse in cycles SETUP_CYC through SETUP_CYC+PULSE_CYC-1, the high-voltage enable and the busy state through cycle SETUP_CYC+PULSE_CYC+HOLD_CYC-1, and ready high in cycle SETUP_CYC+PULSE_CYC+HOLD_CYC. It checks every output in every one of those cycles, one nanosecond after the falling edge. An intruding write and a switch flip are injected at fixed values of k, and the same per-cycle expectations must still hold.

// File: rtl/eprog_pkg.sv
package eprog_pkg;

    localparam int BUS_AW   = 16;
    localparam int DW       = 8;
    localparam int SOCK_CNT = 8;
    localparam int SOCK_AW  = 10;
    localparam int SOCK_IW  = $clog2(SOCK_CNT);
    localparam int WIN_AW   = SOCK_AW + SOCK_IW;
    localparam int BASE_W   = BUS_AW - WIN_AW;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_HOLD  = 2'd3
    } phase_t;

    typedef struct packed {
        logic [SOCK_IW-1:0] sock;
        logic [SOCK_AW-1:0] off;
        logic [DW-1:0]      data;
        logic               hv_ok;
    } prog_req_t;

    function automatic logic [SOCK_CNT-1:0] sock_onehot(input logic [SOCK_IW-1:0] s);
        logic [SOCK_CNT-1:0] r;
        r = '0;
        r[s] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/eprog_window_decode.sv
module eprog_window_decode
    import eprog_pkg::*;
(
    input  logic [BUS_AW-1:0]  addr,
    input  logic [BASE_W-1:0]  base,
    output logic               hit,
    output logic [SOCK_IW-1:0] sock,
    output logic [SOCK_AW-1:0] off
);
    always_comb begin
        hit  = (addr[BUS_AW-1 -: BASE_W] == base);
        sock = addr[WIN_AW-1:SOCK_AW];
        off  = addr[SOCK_AW-1:0];
    end
endmodule

// File: rtl/eprog_phase_seq.sv
module eprog_phase_seq
    import eprog_pkg::*;
#(
    parameter int SETUP_CYC = 4,
    parameter int PULSE_CYC = 16,
    parameter int HOLD_CYC  = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_t phase
);
    localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) phase <= PH_SETUP;
                end
                PH_SETUP: begin
                    if (cnt == CNT_W'(SETUP_CYC - 1)) begin
                        phase <= PH_PULSE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_PULSE: begin
                    if (cnt == CNT_W'(PULSE_CYC - 1)) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    if (cnt == CNT_W'(HOLD_CYC - 1)) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // R5: the pulse phase is entered only from setup
    assert_pulse_after_setup_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PULSE && $past(phase) != PH_PULSE) |-> $past(phase) == PH_SETUP);

    // R3: leaving the busy phases only happens from hold
    assert_idle_after_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && $past(phase) != PH_IDLE) |-> $past(phase) == PH_HOLD);

endmodule

// File: rtl/eprog_bus_if.sv
module eprog_bus_if
    import eprog_pkg::*;
#(
    parameter int SETUP_CYC = 4,
    parameter int PULSE_CYC = 16,
    parameter int HOLD_CYC  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BASE_W-1:0]   base_sel,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic                prog_sw,
    input  logic [DW-1:0]       eprom_rdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                bus_ready,
    output logic [SOCK_CNT-1:0] sock_sel,
    output logic [SOCK_AW-1:0]  eprom_addr,
    output logic [DW-1:0]       eprom_wdata,
    output logic                hv_sel_en,
    output logic                prog_pulse
);
    logic               hit;
    logic [SOCK_IW-1:0] dec_sock;
    logic [SOCK_AW-1:0] dec_off;
    phase_t             phase;
    prog_req_t          req_q;
    logic               idle, rd_hit, wr_hit, start;

    eprog_window_decode u_dec (
        .addr (bus_addr),
        .base (base_sel),
        .hit  (hit),
        .sock (dec_sock),
        .off  (dec_off)
    );

    eprog_phase_seq #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase)
    );

    always_comb begin
        idle   = (phase == PH_IDLE);
        rd_hit = bus_rd && hit;
        wr_hit = bus_wr && hit;
        start  = idle && wr_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (start) begin
            req_q.sock  <= dec_sock;
            req_q.off   <= dec_off;
            req_q.data  <= bus_wdata;
            req_q.hv_ok <= prog_sw;
        end
    end

    always_comb begin
        bus_ready   = idle && !wr_hit;
        bus_rdata   = (idle && rd_hit) ? eprom_rdata : '0;
        eprom_wdata = req_q.data;
        hv_sel_en   = !idle && req_q.hv_ok;
        prog_pulse  = (phase == PH_PULSE) && req_q.hv_ok;
        if (idle) begin
            sock_sel   = (rd_hit || wr_hit) ? sock_onehot(dec_sock) : '0;
            eprom_addr = dec_off;
        end else begin
            sock_sel   = sock_onehot(req_q.sock);
            eprom_addr = req_q.off;
        end
    end

    // R5: pulse only while the high-voltage select is up
    assert_pulse_under_hv_R5: assert property (@(posedge clk) disable iff (rst)
        prog_pulse |-> hv_sel_en);

    // R4: high-voltage select leads the pulse
    assert_hv_leads_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_pulse) |-> $past(hv_sel_en));

    // R3: no ready while a cycle runs
    assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> !bus_ready);

    // R1: at most one socket selected
    assert_one_socket_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sock_sel));

    // R8: captured target stays frozen through a cycle
    assert_target_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> ($stable(eprom_addr) && $stable(sock_sel)));

endmodule

// File: tb/eprog_bus_if_tb.sv
`timescale 1ns/1ps
module eprog_bus_if_tb_top;
    localparam int S = 4;
    localparam int P = 16;
    localparam int H = 3;
    localparam int T = S + P + H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  base_sel = 3'd7;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        prog_sw = 1'b0;
    logic [7:0]  eprom_rdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        bus_ready;
    logic [7:0]  sock_sel;
    logic [9:0]  eprom_addr;
    logic [7:0]  eprom_wdata;
    logic        hv_sel_en;
    logic        prog_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    eprog_bus_if #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) dut_i (
        .clk(clk), .rst(rst), .base_sel(base_sel), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr), .prog_sw(prog_sw),
        .eprom_rdata(eprom_rdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .sock_sel(sock_sel), .eprom_addr(eprom_addr), .eprom_wdata(eprom_wdata),
        .hv_sel_en(hv_sel_en), .prog_pulse(prog_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] oh(input logic [15:0] a);
        return 8'd1 << a[12:10];
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R9 ready in reset", bus_ready, 1);
        chk("R9 hv in reset", hv_sel_en, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R9 ready after reset", bus_ready, 1);
        chk("R9 pulse after reset", prog_pulse, 0);
        chk("R9 sock after reset", sock_sel, 0);
    endtask

    task automatic t_read(input logic [15:0] a, input logic [7:0] d, input logic exp_hit);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; eprom_rdata = d;
        #1;
        chk("R1 read sock_sel", sock_sel, exp_hit ? oh(a) : 8'h00);
        if (exp_hit) chk("R1 read offset", eprom_addr, a[9:0]);
        chk("R2 read data", bus_rdata, exp_hit ? d : 8'h00);
        chk("R2 read ready", bus_ready, 1);
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        chk("R2 no read data", bus_rdata, 0);
    endtask

    task automatic t_write_miss(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; prog_sw = 1'b1;
        #1;
        chk("R7 miss ready", bus_ready, 1);
        chk("R7 miss sock", sock_sel, 0);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R7 miss still ready", bus_ready, 1);
        chk("R7 miss no hv", hv_sel_en, 0);
    endtask

    // intrude_k < 0: no intruding write
    task automatic t_prog(input logic [15:0] a, input logic [7:0] d, input logic sw,
                          input int intrude_k);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; prog_sw = sw;
        #1;
        chk("R3 ready drops same cycle", bus_ready, 0);
        chk("R1 write sock_sel", sock_sel, oh(a));
        for (int k = 0; k <= T; k++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            if (k == 1) prog_sw = ~sw;
            if (k == intrude_k) begin
                bus_wr = 1'b1;
                bus_addr = {a[15:13], ~a[12:10], ~a[9:0]};
                bus_wdata = ~d;
            end
            #1;
            chk("R3 ready timing", bus_ready, (k == T));
            chk(sw ? "R4 hv window" : "R6 hv off", hv_sel_en, sw && (k < T));
            chk(sw ? "R5 pulse window" : "R6 pulse off", prog_pulse, sw && k >= S && k < S + P);
            if (k < T) begin
                chk(intrude_k >= 0 ? "R8 sock held" : "R6 sock held", sock_sel, oh(a));
                chk(intrude_k >= 0 ? "R8 addr held" : "R1 addr held", eprom_addr, a[9:0]);
                chk(intrude_k >= 0 ? "R8 data held" : "R3 data held", eprom_wdata, d);
            end else begin
                chk("R3 sock idle after", sock_sel, 0);
            end
        end
        @(negedge clk);
        #1;
        chk("R8 no restart", bus_ready, 1);
        chk("R8 no hv restart", hv_sel_en, 0);
        prog_sw = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_read(16'hE000, 8'h5A, 1'b1);
        t_read(16'hFFFF, 8'hC3, 1'b1);
        t_read(16'hE7A5, 8'h11, 1'b1);
        t_read(16'h6123, 8'h77, 1'b0);
        t_write_miss(16'h1234);
        t_write_miss(16'hDFFF);
        t_prog(16'hE4C7, 8'hA5, 1'b1, -1);
        t_prog(16'hF801, 8'h3C, 1'b0, -1);
        t_prog(16'hEC3F, 8'h96, 1'b1, 2);
        t_prog(16'hE3FF, 8'h01, 1'b1, S + 1);
        base_sel = 3'd3;
        t_read(16'h6C00, 8'hEE, 1'b1);
        t_read(16'hE000, 8'hEE, 1'b0);
        t_prog(16'h7400, 8'hF0, 1'b1, -1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule